// File: doc/BRIEF.md
# SPI ADC channel scan sequencer

This block is the host side of a 16-bit-frame SPI link to a multi-channel successive-approximation converter. It has two jobs. The first is a scan over a channel mask: it sends one manual conversion command for each selected channel, in ascending channel order, and then two all-zero filler frames. The converter hands back each conversion two frames after the command that asked for it, so the filler frames are needed to collect the last samples. The second job is a single-channel read: the command goes out twice, an all-zero frame follows, and the word that comes back in that third frame is the result.

Each returned word carries the channel index of its sample in its top four bits, with a left-justified 12-bit sample field below. The sequencer knows which channel it expects in every frame. It reports the expected channel, the right-aligned sample cut to the configured resolution, and a mismatch flag. These go out as one beat on a valid/ready stream.

After reset the block configures the converter before it accepts any request. It sends a settings write that selects the doubled input range, then a port-configuration word with every setting cleared. The serial clock is a divided copy of the system clock in SPI mode 0.

Top module: `adc_scan_seq`

## Requirements
- R1: Every frame has exactly 16 serial-clock rising edges while chip select is low, and data is sent MSB first. The serial clock idles low whenever chip select is high. Chip select goes high for at least one system cycle between frames. MOSI changes only while the serial clock is low, and MISO is sampled on the rising edge.
- R2: After reset the block sends exactly two frames and nothing else: 0x1840 (manual bit 12, write bit 11, range bit 6), then 0x4000 (port-configuration bit 14, all settings zero). It produces no result beat and ignores start until both frames are done.
- R3: A conversion command is 0x1000 with the channel number in bits 10:7 (channel c gives 0x1000 | c<<7).
- R4: A scan sends one conversion command for each set mask bit, in ascending channel order, followed by exactly two 0x0000 frames: popcount(mask)+2 frames in total.
- R5: The word received in frame k+2 of an operation is the result of the command sent in frame k. A scan emits exactly one beat per selected channel, in ascending order, and the words from the first two frames are discarded.
- R6: A single read of channel c sends the conversion command for c twice, then 0x0000, and emits exactly one beat, taken from the third frame's returned word.
- R7: The beat's data is bits 11 down to 12-RES_BITS of the returned word, right-aligned.
- R8: The beat's channel is the expected channel. Its error flag is 1 exactly when bits 15:12 of the returned word differ from that channel.
- R9: A beat and its fields stay stable until accepted with ready. No frame starts while a beat is waiting.
- R10: Busy is high from an accepted start until the operation's last beat is accepted. A start seen while busy is ignored.
- R11: A scan start with an all-zero mask and single-read select low is ignored: no frames are sent and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| single_i | input | 1 | 1 selects a single-channel read, 0 selects a mask scan |
| single_ch_i | input | 4 | Channel for a single read |
| chan_mask_i | input | NUM_CH | Channels to scan, bit i selects channel i |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the converter |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select, one assertion per frame |
| res_valid_o | output | 1 | Result beat present |
| res_ready_i | input | 1 | Sink accepts the beat |
| res_chan_o | output | 4 | Expected channel of the beat |
| res_data_o | output | RES_BITS | Right-aligned sample |
| tag_err_o | output | 1 | Returned channel tag did not match |
| busy_o | output | 1 | Initialization, operation or unaccepted beat in progress |

## Verification
A corrupted pending mask or repeat counter shows on MOSI as a wrong, missing or extra command word in the very next frame. A misaligned tag history shows up as a wrong channel, a spurious error flag or a missing beat within two frames. A result slot or start gate stuck in the wrong state shows as a frame that starts while a beat waits, or as busy falling early, within one frame gap. The bench's converter model decodes every frame, keeps its own two-frame delay, and builds each expected beat from the request alone, so every one of these faults is caught at the ports.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int FRAME_W = 16;
    localparam int CH_W    = 4;

    // command word fields
    localparam logic [FRAME_W-1:0] CW_MANUAL     = 16'h1000;
    localparam logic [FRAME_W-1:0] CW_WRITE      = 16'h0800;
    localparam logic [FRAME_W-1:0] CW_WIDE_RANGE = 16'h0040;
    localparam logic [FRAME_W-1:0] CW_PORT_CFG   = 16'h4000;
    localparam logic [FRAME_W-1:0] CW_FILLER     = 16'h0000;
    localparam int                 CW_CH_LSB     = 7;

    // one entry per launched frame: does its reply become a beat, and for which channel
    typedef struct packed {
        logic            want;
        logic [CH_W-1:0] ch;
    } frame_tag_t;

    typedef enum logic [3:0] {
        SQ_BOOT_RANGE,
        SQ_BOOT_PORT,
        SQ_IDLE,
        SQ_SCAN_CMD,
        SQ_SCAN_FILL,
        SQ_ONE_CMD,
        SQ_ONE_FILL,
        SQ_DRAIN
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_GAP
    } phy_state_t;

    function automatic logic [FRAME_W-1:0] conv_word(input logic [CH_W-1:0] ch);
        return CW_MANUAL | (FRAME_W'(ch) << CW_CH_LSB);
    endfunction

endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
    import adc_scan_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int CS_GAP    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_i,
    input  logic [FRAME_W-1:0] word_i,
    output logic               idle_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] rx_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic               cs_n_o,
    input  logic               miso_i
);

    localparam int TMR_MAX = (SCLK_HALF > CS_GAP) ? SCLK_HALF : CS_GAP;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int BIT_W   = $clog2(FRAME_W);

    phy_state_t         ph, ph_nxt;
    logic [TMR_W-1:0]   tmr;
    logic [BIT_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] tx_sr;
    logic [FRAME_W-1:0] rx_sr;
    logic               half_hit;
    logic               gap_hit;
    logic               last_bit;

    assign half_hit = (tmr == TMR_W'(SCLK_HALF - 1));
    assign gap_hit  = (tmr == TMR_W'(CS_GAP - 1));
    assign last_bit = (bit_idx == BIT_W'(FRAME_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= PH_IDLE;
        else        ph <= ph_nxt;
    end

    // next state
    always_comb begin
        ph_nxt = ph;
        unique case (ph)
            PH_IDLE: if (launch_i) ph_nxt = PH_LEAD;
            PH_LEAD: if (half_hit) ph_nxt = PH_HIGH;
            PH_HIGH: if (half_hit) ph_nxt = last_bit ? PH_GAP : PH_LOW;
            PH_LOW:  if (half_hit) ph_nxt = PH_HIGH;
            PH_GAP:  if (gap_hit)  ph_nxt = PH_IDLE;
            default: ph_nxt = PH_IDLE;
        endcase
    end

    // outputs and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr     <= '0;
            bit_idx <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_o    <= '0;
            sclk_o  <= 1'b0;
            cs_n_o  <= 1'b1;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (ph_nxt != ph)       tmr <= '0;
            else if (ph != PH_IDLE) tmr <= tmr + 1'b1;

            if (ph == PH_IDLE && launch_i) begin
                cs_n_o  <= 1'b0;
                tx_sr   <= word_i;
                bit_idx <= '0;
            end
            if (ph_nxt == PH_HIGH && ph != PH_HIGH) begin
                sclk_o <= 1'b1;
                rx_sr  <= {rx_sr[FRAME_W-2:0], miso_i};
            end
            if (ph == PH_HIGH && ph_nxt != PH_HIGH) begin
                sclk_o <= 1'b0;
                if (ph_nxt == PH_GAP) begin
                    cs_n_o <= 1'b1;
                end else begin
                    tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
                    bit_idx <= bit_idx + 1'b1;
                end
            end
            if (ph == PH_GAP && ph_nxt == PH_IDLE) begin
                done_o <= 1'b1;
                rx_o   <= rx_sr;
            end
        end
    end

    assign mosi_o = tx_sr[FRAME_W-1];
    assign idle_o = (ph == PH_IDLE);

endmodule

// File: rtl/adc_scan_ctl.sv
module adc_scan_ctl
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               single_i,
    input  logic [CH_W-1:0]    single_ch_i,
    input  logic [NUM_CH-1:0]  chan_mask_i,
    input  logic               eng_idle_i,
    input  logic               eng_done_i,
    input  logic               slot_full_i,
    output logic               launch_o,
    output logic [FRAME_W-1:0] word_o,
    output frame_tag_t         reply_tag_o,
    output logic               active_o
);

    localparam int HIST_D = 3;

    seq_state_t        state, state_nxt;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] pend_rest;
    logic [CH_W-1:0]   low_ch;
    logic [CH_W-1:0]   one_ch;
    logic              rep;
    logic              can_go;
    logic              sending;
    logic              take_start;
    frame_tag_t        new_tag;
    frame_tag_t        hist [HIST_D];

    // lowest pending channel; clearing the lowest set bit matches it
    always_comb begin
        low_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) low_ch = CH_W'(i);
        end
    end
    assign pend_rest = pend & (pend - 1'b1);

    assign can_go     = eng_idle_i && !eng_done_i && !slot_full_i;
    assign take_start = (state == SQ_IDLE) && !slot_full_i && start_i &&
                        (single_i || (|chan_mask_i));

    // frame content per state
    always_comb begin
        sending = 1'b1;
        word_o  = CW_FILLER;
        new_tag = '{want: 1'b0, ch: '0};
        unique case (state)
            SQ_BOOT_RANGE: word_o = CW_MANUAL | CW_WRITE | CW_WIDE_RANGE;
            SQ_BOOT_PORT:  word_o = CW_PORT_CFG;
            SQ_SCAN_CMD: begin
                word_o  = conv_word(low_ch);
                new_tag = '{want: 1'b1, ch: low_ch};
            end
            SQ_SCAN_FILL:  word_o = CW_FILLER;
            SQ_ONE_CMD: begin
                word_o  = conv_word(one_ch);
                new_tag = '{want: !rep, ch: one_ch};
            end
            SQ_ONE_FILL:   word_o = CW_FILLER;
            SQ_IDLE:       sending = 1'b0;
            SQ_DRAIN:      sending = 1'b0;
            default:       sending = 1'b0;
        endcase
    end

    assign launch_o = sending && can_go;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_BOOT_RANGE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            SQ_BOOT_RANGE: if (launch_o) state_nxt = SQ_BOOT_PORT;
            SQ_BOOT_PORT:  if (launch_o) state_nxt = SQ_DRAIN;
            SQ_IDLE: begin
                if (take_start) state_nxt = single_i ? SQ_ONE_CMD : SQ_SCAN_CMD;
            end
            SQ_SCAN_CMD:   if (launch_o && pend_rest == '0) state_nxt = SQ_SCAN_FILL;
            SQ_SCAN_FILL:  if (launch_o && rep) state_nxt = SQ_DRAIN;
            SQ_ONE_CMD:    if (launch_o && rep) state_nxt = SQ_ONE_FILL;
            SQ_ONE_FILL:   if (launch_o) state_nxt = SQ_DRAIN;
            SQ_DRAIN:      if (eng_done_i) state_nxt = SQ_IDLE;
            default:       state_nxt = SQ_IDLE;
        endcase
    end

    // operation registers and reply-tag history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= '0;
            one_ch <= '0;
            rep    <= 1'b0;
            for (int i = 0; i < HIST_D; i++) hist[i] <= '{want: 1'b0, ch: '0};
        end else begin
            if (take_start) begin
                pend   <= chan_mask_i;
                one_ch <= single_ch_i;
                rep    <= 1'b0;
                for (int i = 0; i < HIST_D; i++) hist[i] <= '{want: 1'b0, ch: '0};
            end
            if (launch_o) begin
                hist[0] <= new_tag;
                for (int i = 1; i < HIST_D; i++) hist[i] <= hist[i-1];
                if (state == SQ_SCAN_CMD) pend <= pend_rest;
                if (state == SQ_SCAN_FILL || state == SQ_ONE_CMD) rep <= !rep;
            end
        end
    end

    assign reply_tag_o = hist[HIST_D-1];
    assign active_o    = (state != SQ_IDLE);

endmodule

// File: rtl/adc_result_slot.sv
module adc_result_slot
    import adc_scan_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_i,
    input  logic [FRAME_W-1:0]  rx_i,
    input  frame_tag_t          tag_i,
    input  logic                ready_i,
    output logic                valid_o,
    output logic [CH_W-1:0]     chan_o,
    output logic [RES_BITS-1:0] data_o,
    output logic                err_o
);

    localparam int SAMPLE_MSB = 11;
    localparam int TAG_LSB    = FRAME_W - CH_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            chan_o  <= '0;
            data_o  <= '0;
            err_o   <= 1'b0;
        end else if (done_i && tag_i.want) begin
            valid_o <= 1'b1;
            chan_o  <= tag_i.ch;
            data_o  <= rx_i[SAMPLE_MSB -: RES_BITS];
            err_o   <= (rx_i[FRAME_W-1:TAG_LSB] != tag_i.ch);
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int RES_BITS  = 12,
    parameter int SCLK_HALF = 2,
    parameter int CS_GAP    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                single_i,
    input  logic [3:0]          single_ch_i,
    input  logic [NUM_CH-1:0]   chan_mask_i,
    output logic                sclk_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic                cs_n_o,
    output logic                res_valid_o,
    input  logic                res_ready_i,
    output logic [3:0]          res_chan_o,
    output logic [RES_BITS-1:0] res_data_o,
    output logic                tag_err_o,
    output logic                busy_o
);

    logic               eng_launch;
    logic [FRAME_W-1:0] eng_word;
    logic               eng_idle;
    logic               eng_done;
    logic [FRAME_W-1:0] eng_rx;
    frame_tag_t         reply_tag;
    logic               seq_active;

    adc_scan_ctl #(.NUM_CH(NUM_CH)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .single_i    (single_i),
        .single_ch_i (single_ch_i),
        .chan_mask_i (chan_mask_i),
        .eng_idle_i  (eng_idle),
        .eng_done_i  (eng_done),
        .slot_full_i (res_valid_o),
        .launch_o    (eng_launch),
        .word_o      (eng_word),
        .reply_tag_o (reply_tag),
        .active_o    (seq_active)
    );

    adc_spi_frame #(.SCLK_HALF(SCLK_HALF), .CS_GAP(CS_GAP)) u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (eng_launch),
        .word_i   (eng_word),
        .idle_o   (eng_idle),
        .done_o   (eng_done),
        .rx_o     (eng_rx),
        .sclk_o   (sclk_o),
        .mosi_o   (mosi_o),
        .cs_n_o   (cs_n_o),
        .miso_i   (miso_i)
    );

    adc_result_slot #(.RES_BITS(RES_BITS)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (eng_done),
        .rx_i    (eng_rx),
        .tag_i   (reply_tag),
        .ready_i (res_ready_i),
        .valid_o (res_valid_o),
        .chan_o  (res_chan_o),
        .data_o  (res_data_o),
        .err_o   (tag_err_o)
    );

    assign busy_o = seq_active || res_valid_o;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int RES_BITS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sclk_o,
    input logic                mosi_o,
    input logic                cs_n_o,
    input logic                res_valid_o,
    input logic                res_ready_i,
    input logic [3:0]          res_chan_o,
    input logic [RES_BITS-1:0] res_data_o,
    input logic                tag_err_o,
    input logic                busy_o
);

    logic [4:0] rise_cnt;
    logic       sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            sclk_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_o;
            if (cs_n_o)                rise_cnt <= '0;
            else if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R1: serial clock rests low while deselected
    a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R1: chip select stays high at least one cycle between frames
    a_r1_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> cs_n_o);

    // R1: sixteen rising edges per frame
    a_r1_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (rise_cnt == 5'd16));

    // R1: MOSI holds while the serial clock is high
    a_r1_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R9: beat held until accepted
    a_r9_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_chan_o) &&
                                           $stable(res_data_o) && $stable(tag_err_o)));

    // R9: no frame begins while a beat waits
    a_r9_no_launch_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && cs_n_o) |=> cs_n_o);

    // R10: a pending beat keeps busy high
    a_r10_busy_covers_beat: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> busy_o);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .cs_n_o      (cs_n_o),
    .res_valid_o (res_valid_o),
    .res_ready_i (res_ready_i),
    .res_chan_o  (res_chan_o),
    .res_data_o  (res_data_o),
    .tag_err_o   (tag_err_o),
    .busy_o      (busy_o)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;

    localparam int RES = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        single_i = 1'b0;
    logic [3:0]  single_ch_i = '0;
    logic [15:0] chan_mask_i = '0;
    logic        sclk_o, mosi_o, cs_n_o;
    logic        miso_i = 1'b0;
    logic        res_valid_o;
    logic        res_ready_i = 1'b0;
    logic [3:0]  res_chan_o;
    logic [RES-1:0] res_data_o;
    logic        tag_err_o;
    logic        busy_o;

    always #2 clk = ~clk;

    adc_scan_seq #(.NUM_CH(16), .RES_BITS(RES), .SCLK_HALF(2), .CS_GAP(2)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .single_i(single_i),
        .single_ch_i(single_ch_i), .chan_mask_i(chan_mask_i), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o), .res_valid_o(res_valid_o),
        .res_ready_i(res_ready_i), .res_chan_o(res_chan_o), .res_data_o(res_data_o),
        .tag_err_o(tag_err_o), .busy_o(busy_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int          salt = 0;
    int          corrupt_ch = -1;
    logic [15:0] sh_out = 16'hFFFF;
    logic [15:0] sh_in  = '0;
    int          bitcnt = 0;
    logic [15:0] older_cmd = 16'hFFFF;
    logic [15:0] next_resp = 16'hFFFF;
    logic [15:0] cmd_log[$];

    function automatic logic [11:0] sample_of(input int ch);
        return 12'((ch * 317 + salt) & 12'hFFF);
    endfunction

    function automatic logic [15:0] resp_for(input logic [15:0] c);
        int ch;
        int tag;
        if (c[15:11] == 5'b00010) begin
            ch  = int'(c[10:7]);
            tag = (ch == corrupt_ch) ? (ch ^ 1) : ch;
            return {4'(tag), sample_of(ch)};
        end
        return 16'hFFFF;
    endfunction

    always @(negedge cs_n_o) begin
        if (rst_n) chk(res_valid_o == 1'b0, "R9", "frame began with beat pending", res_valid_o, 0);
        sh_out = next_resp;
        miso_i = sh_out[15];
        sh_in  = '0;
        bitcnt = 0;
    end
    always @(posedge sclk_o) if (!cs_n_o) begin
        sh_in  = {sh_in[14:0], mosi_o};
        bitcnt = bitcnt + 1;
    end
    always @(negedge sclk_o) if (!cs_n_o) begin
        sh_out = {sh_out[14:0], 1'b1};
        miso_i = sh_out[15];
    end
    always @(posedge cs_n_o) if (bitcnt == 16) begin
        cmd_log.push_back(sh_in);
        next_resp = resp_for(older_cmd);
        older_cmd = sh_in;
        bitcnt    = 0;
    end

    // ---------------- stream monitor ----------------
    int          exp_ch[$];
    int          exp_data[$];
    bit          exp_err[$];
    bit          rand_ready = 1'b0;
    bit          force_ready = 1'b1;
    logic [7:0]  lfsr = 8'hA5;
    bit          prev_hold = 1'b0;
    logic [RES+4:0] prev_beat = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold)
                chk(res_valid_o && {res_chan_o, res_data_o, tag_err_o} == prev_beat,
                    "R9", "beat changed while stalled", {res_chan_o, res_data_o, tag_err_o}, prev_beat);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            res_ready_i = rand_ready ? lfsr[0] : force_ready;
            if (res_valid_o && res_ready_i) begin
                if (exp_ch.size() == 0) begin
                    chk(1'b0, "R5", "unexpected beat on channel", res_chan_o, 0);
                end else begin
                    int ech;
                    int edt;
                    bit eer;
                    ech = exp_ch.pop_front();
                    edt = exp_data.pop_front();
                    eer = exp_err.pop_front();
                    chk(int'(res_chan_o) == ech, "R5", "beat channel", res_chan_o, ech);
                    chk(int'(res_data_o) == edt, "R7", "beat data", res_data_o, edt);
                    chk(tag_err_o == eer, "R8", "tag error flag", tag_err_o, eer);
                end
            end
            prev_hold = res_valid_o && !res_ready_i;
            prev_beat = {res_chan_o, res_data_o, tag_err_o};
        end
    end

    task automatic expect_beat(input int ch);
        exp_ch.push_back(ch);
        exp_data.push_back(int'(sample_of(ch) >> (12 - RES)));
        exp_err.push_back(ch == corrupt_ch);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy_o && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(!busy_o, "R10", "busy never fell", busy_o, 0);
    endtask

    // one operation; poke>0 pulses a foreign start after that many cycles,
    // hold>0 stalls the first beat for that many cycles while busy is watched
    task automatic run_op(input bit one, input int ch, input logic [15:0] mask,
                          input int poke, input int hold, input string req);
        logic [15:0] ecmd[$];
        if (one) begin
            ecmd.push_back(16'h1000 | (16'(ch) << 7));
            ecmd.push_back(16'h1000 | (16'(ch) << 7));
            ecmd.push_back(16'h0000);
            expect_beat(ch);
        end else begin
            for (int i = 0; i < 16; i++) if (mask[i]) begin
                ecmd.push_back(16'h1000 | (16'(i) << 7));
                expect_beat(i);
            end
            ecmd.push_back(16'h0000);
            ecmd.push_back(16'h0000);
        end
        cmd_log.delete();
        if (hold > 0) begin rand_ready = 1'b0; force_ready = 1'b0; end
        @(negedge clk);
        start_i = 1'b1; single_i = one; single_ch_i = 4'(ch); chan_mask_i = mask;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R10", "busy after start", busy_o, 1);
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            start_i = 1'b1; single_i = 1'b0; chan_mask_i = 16'hF0F0;
            @(negedge clk);
            start_i = 1'b0;
        end
        if (hold > 0) begin
            int guard = 0;
            while (!res_valid_o && guard < 20000) begin @(negedge clk); guard++; end
            for (int k = 0; k < hold; k++) begin
                chk(busy_o, "R10", "busy with beat pending", busy_o, 1);
                @(negedge clk);
            end
            force_ready = 1'b1;
        end
        wait_idle();
        chk(cmd_log.size() == ecmd.size(), req, "frame count", cmd_log.size(), ecmd.size());
        for (int i = 0; i < ecmd.size() && i < cmd_log.size(); i++)
            chk(cmd_log[i] == ecmd[i], req, $sformatf("command word %0d", i), cmd_log[i], ecmd[i]);
        chk(exp_ch.size() == 0, "R5", "beats still owed", exp_ch.size(), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1'b1, "R1", "cs_n in reset", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R1", "sclk in reset", sclk_o, 0);
        chk(res_valid_o == 1'b0, "R9", "valid in reset", res_valid_o, 0);
        chk(busy_o == 1'b1, "R2", "busy while configuration pending", busy_o, 1);
        rst_n = 1'b1;

        // R2: configuration frames; a start during them is ignored (R10)
        repeat (4) @(negedge clk);
        start_i = 1'b1; chan_mask_i = 16'h0001;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk(cmd_log.size() == 2, "R2", "boot frame count", cmd_log.size(), 2);
        if (cmd_log.size() == 2) begin
            chk(cmd_log[0] == 16'h1840, "R2", "range write word", cmd_log[0], 16'h1840);
            chk(cmd_log[1] == 16'h4000, "R2", "port config word", cmd_log[1], 16'h4000);
        end

        // R3 R4 R5 R7: single channel scan, ready always high
        salt = 5;
        run_op(1'b0, 0, 16'h0001, 0, 0, "R4");

        // R4 R5: sparse scan with random back-pressure (R9)
        rand_ready = 1'b1;
        salt = 91;
        run_op(1'b0, 0, 16'h8421, 0, 0, "R4");

        // R4: full mask
        salt = 1234;
        run_op(1'b0, 0, 16'hFFFF, 0, 0, "R3");

        // R10: start during scan ignored
        salt = 77;
        run_op(1'b0, 0, 16'h0300, 40, 0, "R10");

        // R11: empty mask ignored
        cmd_log.delete();
        @(negedge clk);
        start_i = 1'b1; single_i = 1'b0; chan_mask_i = 16'h0000;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o, "R11", "busy after empty start", busy_o, 0);
        repeat (200) @(negedge clk);
        chk(!busy_o, "R11", "busy later", busy_o, 0);
        chk(cmd_log.size() == 0, "R11", "frames after empty start", cmd_log.size(), 0);

        // R6: single reads, stale replies from earlier frames must be dropped
        salt = 300;
        run_op(1'b1, 5, 16'h0000, 0, 0, "R6");
        salt = 41;
        run_op(1'b1, 15, 16'h0000, 0, 0, "R6");

        // R8: corrupted tag on channel 3
        corrupt_ch = 3;
        salt = 2000;
        run_op(1'b0, 0, 16'h000C, 0, 0, "R8");
        run_op(1'b1, 3, 16'h0000, 0, 0, "R8");
        corrupt_ch = -1;

        // R10 R9: first beat stalled, busy must hold
        salt = 9;
        run_op(1'b0, 0, 16'h0410, 0, 25, "R10");

        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule